// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a serial-memory command decoder and handles the programming path. The front end reports a starting byte address, then one strobe per complete data byte received. The block stages those bytes in an eight-byte page buffer. The upper address bits are frozen at the start. The page offset advances with each byte and wraps inside the page, so a long burst overwrites the slots it already filled.

When chip select is released, the front end raises a one-cycle release pulse and reports how many bits of an unfinished byte it holds. A write is committed only when all of the following hold:

- no partial byte is pending;
- at least one byte has been staged;
- the write-enable latch is set;
- the write-allowed qualifier has stayed high for the whole transaction.

A committed write starts a self-timed programming cycle of a fixed number of clocks, with busy asserted throughout. During the first page-size clocks of that cycle the block copies every staged slot, and only those, to the storage array through a one-byte write port. The write-enable latch, which the decoder sets and clears with one-cycle pulses, clears itself when the cycle ends.

Top module: `pwb_page_writer`

## Requirements
- R1: After reset, busy, the write-enable latch and the array write strobe are all low.
- R2: A set pulse raises the write-enable latch and a clear pulse lowers it. When both arrive in the same cycle, clear wins.
- R3: Byte k of a transaction (k counted from 0) is stored at page offset (start offset + k) mod 8. The array address is formed from the start address's upper bits (address bits above bit 2) and that offset.
- R4: When more than eight bytes are sent, the offset wraps and each location ends up holding the last byte sent to it.
- R5: A committed write asserts the array write strobe exactly once for each distinct offset received, only while busy, and leaves unreceived locations of the page unchanged.
- R6: Releasing chip select while the partial-bit count is nonzero, or with no complete byte staged, starts no cycle and writes nothing.
- R7: Releasing chip select while the write-enable latch is clear, or while the write-allowed qualifier is low, starts no cycle and writes nothing.
- R8: If the write-allowed qualifier is low in any cycle of the transaction, the write is cancelled, even if the qualifier is high again at the release.
- R9: Busy rises on the clock edge that samples a committing release and stays high for exactly WRITE_CYCLES clocks. The write-enable latch is low when busy falls.
- R10: While busy, these inputs are ignored: start, byte, release, latch set and latch clear pulses, and the write-allowed qualifier. The cycle finishes with all its array writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that opens a write transaction |
| start_addr_i | input | AW | Starting byte address |
| byte_valid_i | input | 1 | One-cycle strobe: a full data byte is present |
| byte_data_i | input | 8 | Data byte |
| cs_rise_i | input | 1 | One-cycle pulse on chip-select release |
| bit_cnt_i | input | 3 | Bits of an unfinished byte held at release |
| wr_allow_i | input | 1 | High when writes are hardware-permitted |
| wel_set_i | input | 1 | Pulse that sets the write-enable latch |
| wel_clr_i | input | 1 | Pulse that clears the write-enable latch |
| busy_o | output | 1 | High during the programming cycle |
| wel_o | output | 1 | Write-enable latch state |
| arr_we_o | output | 1 | Array byte write strobe |
| arr_addr_o | output | AW | Array write address |
| arr_wdata_o | output | 8 | Array write data |

## Verification
The bench sweeps every start offset within a page against burst lengths from one to ten bytes. This catches an offset that carries into the upper address bits (writes land in the neighbouring page) and a missing wrap (ninth and tenth bytes go astray). It also catches a drain that copies stale slots: extra writes corrupt untouched locations.

Releases with a partial byte, an empty buffer, a clear latch, or a qualifier that dropped for only one mid-transaction cycle are each checked to leave busy low and the array unchanged. A design that sampled the qualifier only at release would commit the cancelled write.

A programming cycle is flooded with commands and a qualifier drop. A design that accepted them would restart the cycle, write extra bytes, or come out of the cycle with the latch still set.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic [1:0] {
    SESS_IDLE = 2'd0,
    SESS_RECV = 2'd1,
    SESS_PROG = 2'd2
  } sess_e;
endpackage

// File: rtl/pwb_page_stage.sv
module pwb_page_stage
  import pwb_pkg::*;
#(
  parameter int AW     = 9,
  parameter int PG_LG2 = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [AW-1:0]        addr_i,
  input  logic                 push_i,
  input  byte_t                data_i,
  input  logic                 hold_i,
  input  logic [PG_LG2-1:0]    rd_slot_i,
  output logic [AW-PG_LG2-1:0] base_o,
  output logic [(1<<PG_LG2)-1:0] mask_o,
  output byte_t                rd_data_o
);
  localparam int PG = 1 << PG_LG2;
  localparam int BW = AW - PG_LG2;

  logic [BW-1:0]     base_q, base_d;
  logic [PG_LG2-1:0] ptr_q, ptr_d;
  logic [PG-1:0]     mask_q, mask_d;
  logic              wr_en;
  byte_t             slot_q [PG];

  assign wr_en = push_i && !load_i;

  always_comb begin
    base_d = base_q;
    ptr_d  = ptr_q;
    mask_d = mask_q;
    if (load_i) begin
      base_d = addr_i[AW-1:PG_LG2];
      ptr_d  = addr_i[PG_LG2-1:0];
      mask_d = '0;
    end else if (push_i) begin
      ptr_d         = ptr_q + 1'b1;
      mask_d[ptr_q] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
      mask_q <= '0;
    end else begin
      base_q <= base_d;
      ptr_q  <= ptr_d;
      mask_q <= mask_d;
    end
  end

  for (genvar g = 0; g < PG; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (wr_en && (ptr_q == PG_LG2'(g))) begin
        slot_q[g] <= data_i;
      end
    end
  end

  assign base_o    = base_q;
  assign mask_o    = mask_q;
  assign rd_data_o = slot_q[rd_slot_i];

  // R10: staged contents frozen while a cycle runs
  p_hold_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(mask_q));

  // R4: offset wraps inside the page
  p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr_q == {PG_LG2{1'b1}}) |=> (ptr_q == '0));

  // R3: upper address bits fixed between loads
  p_base_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(base_q));
endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
  parameter int CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic run_o,
  output logic done_o,
  output logic [((CYC > 1) ? $clog2(CYC) : 1)-1:0] elapsed_o
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign done_o = run_q && (cnt_q == LAST);

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (go_i) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q) begin
      if (cnt_q == LAST) begin
        run_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign run_o     = run_q;
  assign elapsed_o = cnt_q;

  // R10: no restart while a cycle runs
  p_go_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !run_q);

  // R9: a run ends exactly after its last count
  p_run_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q == LAST) |=> !run_q);
endmodule

// File: rtl/pwb_page_writer.sv
module pwb_page_writer
  import pwb_pkg::*;
#(
  parameter int AW           = 9,
  parameter int PG_LG2       = 3,
  parameter int WRITE_CYCLES = 16  // must be at least 1 << PG_LG2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          byte_valid_i,
  input  logic [7:0]    byte_data_i,
  input  logic          cs_rise_i,
  input  logic [2:0]    bit_cnt_i,
  input  logic          wr_allow_i,
  input  logic          wel_set_i,
  input  logic          wel_clr_i,
  output logic          busy_o,
  output logic          wel_o,
  output logic          arr_we_o,
  output logic [AW-1:0] arr_addr_o,
  output logic [7:0]    arr_wdata_o
);
  localparam int PG = 1 << PG_LG2;
  localparam int BW = AW - PG_LG2;
  localparam int CW = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;

  sess_e             state_q, state_d;
  logic              cancel_q, cancel_d;
  logic              wel_q, wel_d;
  logic              load, push, go, commit_ok;
  logic              run, done;
  logic [CW-1:0]     elapsed;
  logic [BW-1:0]     base;
  logic [PG-1:0]     mask;
  logic [PG_LG2-1:0] drain_slot;
  logic              drain_active;
  byte_t             drain_data;

  pwb_page_stage #(.AW(AW), .PG_LG2(PG_LG2)) stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .addr_i    (start_addr_i),
    .push_i    (push),
    .data_i    (byte_data_i),
    .hold_i    (run),
    .rd_slot_i (drain_slot),
    .base_o    (base),
    .mask_o    (mask),
    .rd_data_o (drain_data)
  );

  pwb_cycle_timer #(.CYC(WRITE_CYCLES)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (go),
    .run_o     (run),
    .done_o    (done),
    .elapsed_o (elapsed)
  );

  assign commit_ok = (bit_cnt_i == 3'd0) && (|mask) && wel_q && !cancel_q && wr_allow_i;

  always_comb begin
    state_d  = state_q;
    cancel_d = cancel_q;
    wel_d    = wel_q;
    load     = 1'b0;
    push     = 1'b0;
    go       = 1'b0;
    case (state_q)
      SESS_IDLE: begin
        if (start_i) begin
          state_d  = SESS_RECV;
          load     = 1'b1;
          cancel_d = !wr_allow_i;
        end
      end
      SESS_RECV: begin
        if (!wr_allow_i) cancel_d = 1'b1;
        if (cs_rise_i) begin
          state_d = SESS_IDLE;
          if (commit_ok) begin
            go      = 1'b1;
            state_d = SESS_PROG;
          end
        end else if (start_i) begin
          load     = 1'b1;
          cancel_d = !wr_allow_i;
        end else if (byte_valid_i) begin
          push = 1'b1;
        end
      end
      SESS_PROG: begin
        if (done) begin
          state_d = SESS_IDLE;
          wel_d   = 1'b0;
        end
      end
      default: state_d = SESS_IDLE;
    endcase
    if (state_q != SESS_PROG) begin
      if (wel_clr_i)      wel_d = 1'b0;
      else if (wel_set_i) wel_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SESS_IDLE;
      cancel_q <= 1'b0;
      wel_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      cancel_q <= cancel_d;
      wel_q    <= wel_d;
    end
  end

  assign drain_slot   = elapsed[PG_LG2-1:0];
  assign drain_active = run && (32'(elapsed) < PG);

  assign busy_o      = run;
  assign wel_o       = wel_q;
  assign arr_we_o    = drain_active && mask[drain_slot];
  assign arr_addr_o  = {base, drain_slot};
  assign arr_wdata_o = drain_data;

  // R5: array is written only inside the programming cycle
  p_we_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> busy_o);

  // R6: a partial byte at release never starts a cycle
  p_partial_no_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_i && bit_cnt_i != 3'd0) |=> !$rose(busy_o));

  // R7: a clear latch blocks the commit
  p_wel_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_i && !wel_o) |=> !$rose(busy_o));

  // R8: a cancelled transaction never commits
  p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SESS_RECV && cancel_q) |=> !$rose(busy_o));

  // R9: latch is clear as the cycle ends
  p_wel_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !wel_o);

  // R9: session state and timer agree
  p_state_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SESS_PROG) == run);

  // R10: latch cannot rise during a cycle
  p_wel_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !$rose(wel_o));
endmodule

// File: tb/pwb_page_writer_tb_top.sv
`timescale 1ns/1ps
module pwb_page_writer_tb_top;
  localparam int AW = 9;
  localparam int WC = 16;
  localparam int MEMN = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i, byte_valid_i, cs_rise_i, wr_allow_i, wel_set_i, wel_clr_i;
  logic [AW-1:0] start_addr_i;
  logic [7:0]    byte_data_i;
  logic [2:0]    bit_cnt_i;
  logic          busy_o, wel_o, arr_we_o;
  logic [AW-1:0] arr_addr_o;
  logic [7:0]    arr_wdata_o;

  int  checks = 0;
  int  errors = 0;
  int  wr_count = 0;
  bit  wel_m = 1'b0;
  bit  finished = 1'b0;
  logic [7:0] obs_mem [MEMN];
  logic [7:0] exp_mem [MEMN];

  always #2.5 clk = ~clk;

  pwb_page_writer #(.AW(AW), .PG_LG2(3), .WRITE_CYCLES(WC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i), .cs_rise_i(cs_rise_i),
    .bit_cnt_i(bit_cnt_i), .wr_allow_i(wr_allow_i), .wel_set_i(wel_set_i),
    .wel_clr_i(wel_clr_i), .busy_o(busy_o), .wel_o(wel_o), .arr_we_o(arr_we_o),
    .arr_addr_o(arr_addr_o), .arr_wdata_o(arr_wdata_o)
  );

  always @(negedge clk) begin
    if (rst_n && arr_we_o) begin
      obs_mem[arr_addr_o] = arr_wdata_o;
      wr_count++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_in();
    start_i = 0; byte_valid_i = 0; cs_rise_i = 0; wel_set_i = 0; wel_clr_i = 0;
    bit_cnt_i = 0; wr_allow_i = 1; start_addr_i = '0; byte_data_i = '0;
  endtask

  task automatic wel_cmd(input bit s, input bit c);
    @(negedge clk); wel_set_i = s; wel_clr_i = c;
    @(negedge clk); wel_set_i = 0; wel_clr_i = 0;
    if (c) wel_m = 0; else if (s) wel_m = 1;
  endtask

  task automatic mem_cmp(input string req);
    int bad = 0;
    for (int a = 0; a < MEMN; a++) if (obs_mem[a] !== exp_mem[a]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic send(input logic [AW-1:0] addr, input int n, input int seed,
                      input logic [2:0] bc, input bit allow_rise, input bit drop,
                      input bit intrude, input string req);
    logic [7:0] pend [8];
    logic [7:0] pmask = '0;
    int w0;
    bit expc;
    @(negedge clk); start_i = 1; start_addr_i = addr;
    @(negedge clk); start_i = 0;
    for (int i = 0; i < n; i++) begin
      int slot = (int'(addr) + i) % 8;
      byte_valid_i = 1;
      byte_data_i  = 8'(seed * 37 + i * 11 + 5);
      pend[slot] = byte_data_i;
      pmask[slot] = 1'b1;
      if (drop && i == 0) wr_allow_i = 0;
      @(negedge clk);
      byte_valid_i = 0; wr_allow_i = 1;
    end
    expc = wel_m && bc == 0 && n > 0 && allow_rise && !drop;
    w0 = wr_count;
    cs_rise_i = 1; bit_cnt_i = bc; wr_allow_i = allow_rise;
    @(negedge clk);
    cs_rise_i = 0; bit_cnt_i = 0; wr_allow_i = 1;
    if (expc) begin
      int cnt = 0;
      while (busy_o && cnt < 4 * WC) begin
        cnt++;
        if (intrude && cnt == 2) begin
          start_i = 1; start_addr_i = '0; byte_valid_i = 1; byte_data_i = 8'hA5;
          cs_rise_i = 1; wel_set_i = 1; wr_allow_i = 0;
        end else begin
          idle_in();
        end
        @(negedge clk);
      end
      idle_in();
      chk(cnt == WC, {req, " R9 busy length"}, cnt, WC);
      chk(wel_o == 1'b0, {req, " R9 latch after cycle"}, wel_o, 0);
      wel_m = 0;
      for (int s = 0; s < 8; s++)
        if (pmask[s]) exp_mem[{addr[AW-1:3], 3'(s)}] = pend[s];
      chk(wr_count - w0 == $countones(pmask), {req, " R5 write count"},
          wr_count - w0, $countones(pmask));
    end else begin
      chk(busy_o == 1'b0, {req, " no cycle"}, busy_o, 0);
      repeat (WC + 2) @(negedge clk);
      chk(wr_count == w0, {req, " no writes"}, wr_count - w0, 0);
    end
    mem_cmp({req, " R3 R4 array contents"});
  endtask

  initial begin
    for (int a = 0; a < MEMN; a++) begin obs_mem[a] = '0; exp_mem[a] = '0; end
    idle_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy_o == 0, "R1 busy", busy_o, 0);
    chk(wel_o == 0, "R1 latch", wel_o, 0);
    chk(arr_we_o == 0, "R1 write strobe", arr_we_o, 0);

    wel_cmd(1, 0); chk(wel_o == 1, "R2 set", wel_o, 1);
    wel_cmd(0, 1); chk(wel_o == 0, "R2 clear", wel_o, 0);
    wel_cmd(1, 0);
    wel_cmd(1, 1); chk(wel_o == 0, "R2 clear wins", wel_o, 0);

    // R3 R4 R5 R9: sweep start offsets and burst lengths
    for (int off = 0; off < 8; off++) begin
      for (int n = 1; n <= 10; n++) begin
        wel_cmd(1, 0);
        send(AW'(((off * 5 + n) % 64) * 8 + off), n, off * 16 + n, 3'd0, 1, 0, 0, "R3");
      end
    end

    // R6: partial byte at release, and empty buffer
    for (int b = 1; b < 8; b++) begin
      wel_cmd(1, 0);
      send(AW'(9'h0A0 + b), 3, 200 + b, 3'(b), 1, 0, 0, "R6 partial");
    end
    wel_cmd(1, 0);
    send(9'h0C8, 0, 0, 3'd0, 1, 0, 0, "R6 empty");

    // R7: latch clear, qualifier low at release
    wel_cmd(0, 1);
    send(9'h110, 4, 77, 3'd0, 1, 0, 0, "R7 latch clear");
    wel_cmd(1, 0);
    send(9'h118, 4, 78, 3'd0, 0, 0, 0, "R7 qualifier low");

    // R8: one-cycle qualifier drop mid-transaction
    wel_cmd(1, 0);
    send(9'h120, 5, 79, 3'd0, 1, 1, 0, "R8 cancelled");

    // R10: commands during a cycle are ignored
    wel_cmd(1, 0);
    send(9'h1F3, 6, 91, 3'd0, 1, 0, 1, "R10 intrusion");
    @(negedge clk); cs_rise_i = 1;
    @(negedge clk); cs_rise_i = 0;
    chk(busy_o == 0, "R10 stray release after cycle", busy_o, 0);
    chk(wel_o == 0, "R10 latch set ignored while busy", wel_o, 0);
    repeat (WC) @(negedge clk);
    mem_cmp("R10 array untouched");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule